// File: doc/BRIEF.md
# Fixed Off-Time Chopper Current Controller

This block is the digital control for a single full-bridge motor winding. It takes a direction input, a 2-bit current-level code, a digitised over-current comparator input and two fault flags. From these it drives the four gate enables of the bridge: a high-side and a low-side switch on each of legs A and B. It also registers a 2-bit reference select that sets an external reference level. The analog comparator, the DAC and the power stage sit outside the block.

Regulation works by current-mode chopping. An on-period turns on the diagonal pair chosen by the direction input. The comparator is ignored for a blanking window at the start of each on-period. When it trips, the high side turns off. After a dead time both low sides conduct, so the winding current recirculates through switches rather than diodes. A one-shot timer sets the off-time and starts the next on-period when it expires. A dead time separates every change between complementary switches. A fault, or the zero-current level code, parks the bridge with every gate off.

The controller is a six-state machine. ST_IDLE has all gates off and is left for ST_PRE_DEAD once there is no fault and the level is nonzero. ST_PRE_DEAD has all gates off for the dead time and then moves to ST_DRIVE. ST_DRIVE enables the diagonal pair and moves to ST_TRIP_DEAD on a trip once the blanking window has expired. ST_TRIP_DEAD keeps only the sink switch on for the dead time and then moves to ST_RECIRC. ST_RECIRC turns on both low sides and moves to ST_RESUME_DEAD when the off-time expires. ST_RESUME_DEAD keeps only the sink on for the dead time and then returns to ST_DRIVE. Three transitions apply from any state. A fault or the zero code goes to ST_IDLE, and this takes priority over everything else. A change of direction outside ST_IDLE goes to ST_PRE_DEAD, and this takes priority over a trip. The parameters must satisfy OFF_CYC > DEAD_CYC + 1.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: While reset is held, all four gate outputs are 0 and ref_sel is 0.
- R2: ref_sel follows lvl_code one cycle later with this encoding: code 00 gives 3 (full current), 01 gives 2 (two-thirds), 10 gives 1 (one-third) and 11 gives 0. Changing between nonzero codes does not disturb the gate outputs.
- R3: From the cycle after lvl_code becomes 11, all gates are off and stay off. Once a nonzero code returns, the gates are all off for DEAD_CYC cycles and the on-period then begins.
- R4: From the cycle after overtemp_in or undervolt_in is high, all gates are off, and they stay off while either flag is high, including after reset. After the flags clear, the gates are all off for DEAD_CYC cycles and the on-period then begins.
- R5: An on-period is preceded by DEAD_CYC cycles with all gates off. It enables gate_hi_a with gate_lo_b when phase_in is 1, and gate_hi_b with gate_lo_a when phase_in is 0.
- R6: trip_in is ignored during the first BLANK_CYC cycles of every on-period. From the cycle at index BLANK_CYC onward (the first cycle of the on-period is index 0), a high trip_in ends the on-period at the next edge.
- R7: After a trip, the high side is off and only the sink low side stays on for DEAD_CYC cycles. After that, both low sides are on.
- R8: The sink-only and both-low intervals after a trip last OFF_CYC cycles in total. They are followed by DEAD_CYC cycles with only the sink on, and then a new on-period with a fresh blanking window.
- R9: The high and low gates of the same leg are never on together. A high gate never turns on in the cycle after the low gate of its own leg was on.
- R10: A change of phase_in in any active state gives all gates off from the next cycle for DEAD_CYC cycles, followed by the new diagonal with a fresh blanking window. This also holds when a trip arrives in the same cycle as the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_in | input | 1 | Direction: 1 drives A high / B low |
| lvl_code | input | 2 | Current-level code (11 = zero current) |
| trip_in | input | 1 | Digitised over-current comparator |
| overtemp_in | input | 1 | Overtemperature fault flag |
| undervolt_in | input | 1 | Undervoltage lockout flag |
| gate_hi_a | output | 1 | Leg A high-side enable |
| gate_lo_a | output | 1 | Leg A low-side enable |
| gate_hi_b | output | 1 | Leg B high-side enable |
| gate_lo_b | output | 1 | Leg B low-side enable |
| ref_sel | output | 2 | Registered reference-level select |

## Verification
Two events can land in the same cycle: a direction change and an unblanked comparator trip during an on-period. The bench raises trip_in and flips phase_in at the same edge, well after the blanking window has closed. The design passes only if all gates go off in the next cycle, instead of showing the sink-only recirculation pattern, and the opposite diagonal appears after exactly DEAD_CYC cycles. The trip level that is still held must then be ignored until a full new blanking window has elapsed.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_DEAD,
        ST_DRIVE,
        ST_TRIP_DEAD,
        ST_RECIRC,
        ST_RESUME_DEAD
    } chop_state_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gate_t;

    localparam int unsigned TMR_DEAD  = 0;
    localparam int unsigned TMR_BLANK = 1;
    localparam int unsigned TMR_OFF   = 2;
    localparam int unsigned TMR_COUNT = 3;

    localparam logic [1:0] LVL_ZERO_CODE = 2'b11;

    // Level code to reference select: 00->3, 01->2, 10->1, 11->0
    function automatic logic [1:0] level_to_ref(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'b00:   r = 2'd3;
            2'b01:   r = 2'd2;
            2'b10:   r = 2'd1;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int unsigned LOAD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int W = $clog2(LOAD + 2);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= W'(LOAD);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R8: counter never exceeds its load value
    a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(LOAD));

    // R8: once expired, it stays expired until restarted
    a_r8_timer_stays_done: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> expired);

endmodule

// File: rtl/chop_level_map.sv
module chop_level_map
    import chop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl_code,
    output logic [1:0] ref_sel,
    output logic       zero_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_sel <= 2'd0;
        end else begin
            ref_sel <= level_to_ref(lvl_code);
        end
    end

    assign zero_req = (lvl_code == LVL_ZERO_CODE);

    // R2: zero code yields reference 0 one cycle later
    a_r2_zero_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_code == 2'b11) |=> (ref_sel == 2'd0));

    // R2: full code yields the highest reference one cycle later
    a_r2_full_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_code == 2'b00) |=> (ref_sel == 2'd3));

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  phase,
    input  logic  trip,
    input  logic  fault,
    input  logic  zero_req,
    input  logic  dead_exp,
    input  logic  blank_exp,
    input  logic  off_exp,
    output logic  dead_start,
    output logic  blank_start,
    output logic  off_start,
    output gate_t gates
);
    chop_state_e st, nxt;
    logic        ph;
    logic        ph_load;

    // State register and latched direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            ph <= 1'b0;
        end else begin
            st <= nxt;
            if (ph_load) begin
                ph <= phase;
            end
        end
    end

    // Next state and timer starts
    always_comb begin
        nxt         = st;
        dead_start  = 1'b0;
        blank_start = 1'b0;
        off_start   = 1'b0;
        ph_load     = 1'b0;
        if (fault || zero_req) begin
            nxt = ST_IDLE;
        end else if (st != ST_IDLE && phase != ph) begin
            nxt        = ST_PRE_DEAD;
            dead_start = 1'b1;
            ph_load    = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    nxt        = ST_PRE_DEAD;
                    dead_start = 1'b1;
                    ph_load    = 1'b1;
                end
                ST_PRE_DEAD: begin
                    if (dead_exp) begin
                        nxt         = ST_DRIVE;
                        blank_start = 1'b1;
                    end
                end
                ST_DRIVE: begin
                    if (blank_exp && trip) begin
                        nxt        = ST_TRIP_DEAD;
                        dead_start = 1'b1;
                        off_start  = 1'b1;
                    end
                end
                ST_TRIP_DEAD: begin
                    if (dead_exp) begin
                        nxt = ST_RECIRC;
                    end
                end
                ST_RECIRC: begin
                    if (off_exp) begin
                        nxt        = ST_RESUME_DEAD;
                        dead_start = 1'b1;
                    end
                end
                ST_RESUME_DEAD: begin
                    if (dead_exp) begin
                        nxt         = ST_DRIVE;
                        blank_start = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Gate outputs decoded from state and latched direction
    always_comb begin
        gates = '0;
        unique case (st)
            ST_DRIVE: begin
                if (ph) begin
                    gates.hi_a = 1'b1;
                    gates.lo_b = 1'b1;
                end else begin
                    gates.hi_b = 1'b1;
                    gates.lo_a = 1'b1;
                end
            end
            ST_TRIP_DEAD, ST_RESUME_DEAD: begin
                if (ph) begin
                    gates.lo_b = 1'b1;
                end else begin
                    gates.lo_a = 1'b1;
                end
            end
            ST_RECIRC: begin
                gates.lo_a = 1'b1;
                gates.lo_b = 1'b1;
            end
            default: gates = '0;
        endcase
    end

    // R5: an on-period always drives exactly two switches
    a_r5_drive_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRIVE) |-> ($countones(gates) == 2));

    // R6: inside the blanking window the drive pattern does not change
    a_r6_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRIVE && !blank_exp && !fault && !zero_req && phase == ph)
        |=> $stable(gates));

    // R7: an unblanked trip removes both high sides and keeps one low side
    a_r7_trip_drops_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRIVE && blank_exp && trip && !fault && !zero_req && phase == ph)
        |=> (!gates.hi_a && !gates.hi_b && (gates.lo_a != gates.lo_b)));

    // R10: a direction change clears every gate next cycle
    a_r10_flip_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && phase != ph && !fault && !zero_req) |=> (gates == '0));

    // R9: high side only turns on after its own low side was off
    a_r9_hi_a_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gates.hi_a) |-> !$past(gates.lo_a));
    a_r9_hi_b_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gates.hi_b) |-> !$past(gates.lo_b));

endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned OFF_CYC   = 3000,
    parameter int unsigned BLANK_CYC = 100,
    parameter int unsigned DEAD_CYC  = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_in,
    input  logic [1:0] lvl_code,
    input  logic       trip_in,
    input  logic       overtemp_in,
    input  logic       undervolt_in,
    output logic       gate_hi_a,
    output logic       gate_lo_a,
    output logic       gate_hi_b,
    output logic       gate_lo_b,
    output logic [1:0] ref_sel
);
    localparam int unsigned TMR_LOAD [TMR_COUNT] = '{DEAD_CYC - 1, BLANK_CYC, OFF_CYC - 1};

    logic [TMR_COUNT-1:0] tmr_start;
    logic [TMR_COUNT-1:0] tmr_exp;
    logic                 zero_req;
    logic                 fault;
    gate_t                gates;

    assign fault = overtemp_in | undervolt_in;

    for (genvar g = 0; g < TMR_COUNT; g++) begin : g_tmr
        chop_timer #(
            .LOAD (TMR_LOAD[g])
        ) i_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (tmr_start[g]),
            .expired (tmr_exp[g])
        );
    end

    chop_level_map i_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_code (lvl_code),
        .ref_sel  (ref_sel),
        .zero_req (zero_req)
    );

    chop_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase_in),
        .trip        (trip_in),
        .fault       (fault),
        .zero_req    (zero_req),
        .dead_exp    (tmr_exp[TMR_DEAD]),
        .blank_exp   (tmr_exp[TMR_BLANK]),
        .off_exp     (tmr_exp[TMR_OFF]),
        .dead_start  (tmr_start[TMR_DEAD]),
        .blank_start (tmr_start[TMR_BLANK]),
        .off_start   (tmr_start[TMR_OFF]),
        .gates       (gates)
    );

    assign gate_hi_a = gates.hi_a;
    assign gate_lo_a = gates.lo_a;
    assign gate_hi_b = gates.hi_b;
    assign gate_lo_b = gates.lo_b;

    // R4: any fault flag clears all gates next cycle
    a_r4_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        (overtemp_in || undervolt_in)
        |=> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b));

    // R3: zero-current code clears all gates next cycle
    a_r3_zero_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_code == 2'b11)
        |=> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b));

    // R9: no shoot-through on either leg
    a_r9_leg_a_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_a && gate_lo_a));
    a_r9_leg_b_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_b && gate_lo_b));

endmodule

// File: tb/test_chop_bridge_ctrl.sv
module test_chop_bridge_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned T_OFF   = 40;
    localparam int unsigned T_BLANK = 8;
    localparam int unsigned T_DEAD  = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       phase_in;
    logic [1:0] lvl_code;
    logic       trip_in;
    logic       overtemp_in;
    logic       undervolt_in;
    logic       gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;
    logic [1:0] ref_sel;

    int cyc = 0;
    int compared = 0;
    int mismatched = 0;
    int overlap = 0;
    bit done = 1'b0;

    typedef struct {
        int         cyc;
        bit         is_ref;
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];

    chop_bridge_ctrl #(
        .OFF_CYC   (T_OFF),
        .BLANK_CYC (T_BLANK),
        .DEAD_CYC  (T_DEAD)
    ) i_chop_bridge_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_in     (phase_in),
        .lvl_code     (lvl_code),
        .trip_in      (trip_in),
        .overtemp_in  (overtemp_in),
        .undervolt_in (undervolt_in),
        .gate_hi_a    (gate_hi_a),
        .gate_lo_a    (gate_lo_a),
        .gate_hi_b    (gate_hi_b),
        .gate_lo_b    (gate_lo_b),
        .ref_sel      (ref_sel)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expectations due in this cycle and compares
    always @(negedge clk) begin
        logic [3:0] act;
        if ((gate_hi_a && gate_lo_a) || (gate_hi_b && gate_lo_b)) overlap++;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                act = q[i].is_ref ? {2'b00, ref_sel} : {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};
                compared++;
                if (act !== q[i].val) begin
                    mismatched++;
                    $display("FAIL %s at cycle %0d: actual %b expected %b",
                             q[i].tag, cyc, act, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic exp_gates(int t, logic [3:0] v, string tag);
        exp_t e;
        e.cyc = t; e.is_ref = 1'b0; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic exp_ref(int t, logic [1:0] v, string tag);
        exp_t e;
        e.cyc = t; e.is_ref = 1'b1; e.val = {2'b00, v}; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic at(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Gate vectors are {hi_a, lo_a, hi_b, lo_b}
    initial begin
        rst_n = 1'b0; undervolt_in = 1'b1; overtemp_in = 1'b0;
        lvl_code = 2'b00; phase_in = 1'b1; trip_in = 1'b0;

        exp_gates(2, 4'b0000, "R1 gates in reset");
        exp_ref(2, 2'd0, "R1 ref in reset");
        exp_ref(5, 2'd3, "R2 code 00 full");
        exp_gates(10, 4'b0000, "R4 undervoltage lockout after reset");
        exp_gates(13, 4'b0000, "R5 pre-dead first");
        exp_gates(16, 4'b0000, "R5 pre-dead last");
        exp_gates(17, 4'b1001, "R5 diagonal phase 1");
        exp_gates(25, 4'b1001, "R6 trip blanked");
        exp_gates(26, 4'b0001, "R7 sink only after trip");
        exp_gates(29, 4'b0001, "R7 sink only end of dead");
        exp_gates(30, 4'b0101, "R7 both low recirc");
        exp_gates(65, 4'b0101, "R8 last off-time cycle");
        exp_gates(66, 4'b0001, "R8 resume dead first");
        exp_gates(69, 4'b0001, "R8 resume dead last");
        exp_gates(70, 4'b1001, "R8 new on-period");
        exp_gates(78, 4'b1001, "R6 second window blanked");
        exp_gates(79, 4'b0001, "R6 second window trip");
        exp_gates(90, 4'b0101, "R10 recirc before flip");
        exp_gates(91, 4'b0000, "R10 all off after flip");
        exp_gates(94, 4'b0000, "R10 dead end");
        exp_gates(95, 4'b0110, "R10 diagonal phase 0");
        exp_gates(103, 4'b0110, "R10 fresh blanking");
        exp_gates(104, 4'b0100, "R10 trip after new window");
        exp_ref(111, 2'd2, "R2 code 01");
        exp_gates(111, 4'b0101, "R2 gates undisturbed");
        exp_ref(113, 2'd1, "R2 code 10");
        exp_ref(115, 2'd0, "R3 code 11 ref");
        exp_gates(115, 4'b0000, "R3 zero level off");
        exp_gates(125, 4'b0000, "R3 zero level stays off");
        exp_ref(127, 2'd3, "R2 code 00 again");
        exp_gates(130, 4'b0000, "R3 restart dead");
        exp_gates(131, 4'b0110, "R3 restart drive");
        exp_gates(136, 4'b0000, "R4 overtemp off");
        exp_gates(150, 4'b0000, "R4 overtemp held");
        exp_gates(154, 4'b0000, "R4 restart dead");
        exp_gates(155, 4'b0110, "R4 restart drive");
        exp_gates(171, 4'b0000, "R10 flip beats trip");
        exp_gates(174, 4'b0000, "R10 flip dead end");
        exp_gates(175, 4'b1001, "R10 new diagonal");
        exp_gates(183, 4'b1001, "R6 held trip blanked");
        exp_gates(184, 4'b0001, "R6 held trip honoured");

        at(4);   rst_n = 1'b1;
        at(12);  undervolt_in = 1'b0; trip_in = 1'b1;
        at(26);  trip_in = 1'b0;
        at(70);  trip_in = 1'b1;
        at(79);  trip_in = 1'b0;
        at(90);  phase_in = 1'b0;
        at(95);  trip_in = 1'b1;
        at(104); trip_in = 1'b0;
        at(110); lvl_code = 2'b01;
        at(112); lvl_code = 2'b10;
        at(114); lvl_code = 2'b11;
        at(126); lvl_code = 2'b00;
        at(135); overtemp_in = 1'b1;
        at(150); overtemp_in = 1'b0;
        at(170); trip_in = 1'b1; phase_in = 1'b1;
        at(190);

        compared++;
        if (overlap != 0) begin
            mismatched++;
            $display("FAIL R9 leg overlap cycles: actual %0d expected 0", overlap);
        end
        if (q.size() != 0) begin
            mismatched += q.size();
            $display("FAIL unconsumed expectations: actual %0d expected 0", q.size());
        end
        summary();
        done = 1'b1;
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule